// File: doc/BRIEF.md
# Script Transfer-Control Branch Unit

This unit resolves one conditional transfer-control instruction of a script engine and works out the next program counter. It is handed a 32-bit instruction word and its 32-bit address operand. It also receives the bus phase currently on the wire, the one-byte compare register, the carry flag, the program counter (already advanced past the instruction) and the saved return-address register. It then decides whether the branch is taken. From that decision it produces the next program counter, an optional write of the return-address register, an optional write of the script status word, and at most one event request. The event request is a halting script interrupt, a non-halting interrupt-on-the-fly, an illegal-instruction fault, or a halt caused by a pending selection timeout.

The instruction class has already been decoded upstream, and the top two instruction bits are not examined here. A one-cycle `start` pulse presents the operands. All results appear together, registered, on the next clock edge, and `done` is high for exactly that one cycle. While `done` is low, every output strobe is low and the unit holds no state between instructions.

Top module: `branch_unit`

## Requirements
- R1: After reset, `done`, `tempWrite`, `statusWrite`, `scriptIrq`, `flyIrq`, `illegalFault` and `timeoutHalt` are all low.
- R2: `done` rises on the clock edge that samples `start` high and stays high for that one cycle only. No output strobe is high while `done` is low.
- R3: Instruction bit 19 is the polarity, and the branch is taken when the combined condition equals it. When bits 21, 18 and 17 are all clear, the branch is taken whatever the value of bit 19.
- R4: When bit 21 is set, the carry flag is the first compare in the chain.
- R5: When bit 17 is set, the phase compare is true when `busPhase` equals instruction bits 26:24.
- R6: When bit 18 is set, the data compare is true when (`sfbrByte` AND mask) equals (bits 7:0 AND mask), with mask = NOT bits 15:8.
- R7: The compares run in the order carry, phase, data. A compare is evaluated only while the result so far still equals the polarity; otherwise the earlier result stands.
- R8: With bit 23 set, the target is `pcIn` plus bits 23:0 of the operand sign-extended. With bit 23 clear, the target is the whole operand.
- R9: Bits 29:27 select the action. Code 0 loads the target into the program counter. Code 1 does the same and also writes the old `pcIn` to `tempOut` with `tempWrite`. Code 2 loads `tempIn` into the program counter.
- R10: Code 3 is an interrupt. With bit 20 set, it raises `flyIrq` and the program counter stays at `pcIn`. With bit 20 clear, it writes the operand to `statusOut` with `statusWrite`, raises `scriptIrq`, and keeps `pcIn`.
- R11: A taken branch with code 4, 5, 6 or 7 raises `illegalFault` and keeps `pcIn`.
- R12: While `selTimeoutPending` is high, no condition is evaluated. Only `timeoutHalt` is raised, and `pcOut` equals `pcIn`.
- R13: When the condition fails, `pcOut` equals `pcIn` and no strobe other than `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to resolve the presented instruction |
| insnWord | input | 32 | Transfer-control instruction word |
| operandWord | input | ADDR_W | Address operand of the instruction |
| busPhase | input | PHASE_W | Current bus phase |
| sfbrByte | input | BYTE_W | Compare data byte |
| carryFlag | input | 1 | Carry flag from the arithmetic unit |
| pcIn | input | ADDR_W | Program counter, already past the instruction |
| tempIn | input | ADDR_W | Saved return address |
| selTimeoutPending | input | 1 | A selection timeout awaits delivery |
| done | output | 1 | Result valid this cycle |
| pcOut | output | ADDR_W | Next program counter |
| tempWrite | output | 1 | Write `tempOut` into the return-address register |
| tempOut | output | ADDR_W | Return address to store |
| statusWrite | output | 1 | Write `statusOut` into the script status register |
| statusOut | output | ADDR_W | Script status value |
| scriptIrq | output | 1 | Halting script interrupt request |
| flyIrq | output | 1 | Interrupt-on-the-fly request |
| illegalFault | output | 1 | Illegal-instruction fault request |
| timeoutHalt | output | 1 | Halt request caused by a pending selection timeout |

## Verification
A taken call is the one instruction in which two state updates fall in the same cycle: the return-address register is written and the program counter is redirected. The bench issues calls with absolute and relative targets. In each case the scoreboard entry carries both the expected `tempOut` (the old program counter) and the expected `pcOut`, and both are compared in the single `done` cycle. A pending selection timeout is also raised together with an otherwise taken branch. That case is judged by requiring `timeoutHalt` alone, with the program counter unchanged and no return-address write.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;

  // Fixed instruction encoding of the transfer-control class
  localparam int INSN_W      = 32;
  localparam int OPC_LO      = 27;
  localparam int OPC_W       = 3;
  localparam int CMP_PH_LO   = 24;
  localparam int REL_BIT     = 23;
  localparam int CARRY_EN    = 21;
  localparam int FLY_BIT     = 20;
  localparam int POL_BIT     = 19;
  localparam int DATA_EN     = 18;
  localparam int PHASE_EN    = 17;
  localparam int MASK_LO     = 8;
  localparam int DATA_LO     = 0;

  typedef enum logic [OPC_W-1:0] {
    OP_JUMP   = 3'd0,
    OP_CALL   = 3'd1,
    OP_RETURN = 3'd2,
    OP_INTR   = 3'd3
  } brOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic relTarget;     // target is pc-relative
    logic pcFromTarget;  // load computed target
    logic pcFromTemp;    // load saved return address
    logic saveTemp;      // save old pc
    logic loadStatus;    // copy operand to status word
    logic raiseHalt;     // halting script interrupt
    logic raiseFly;      // interrupt on the fly
    logic raiseIllegal;  // illegal instruction
    logic timeoutStop;   // selection timeout halt
  } brStrobe_t;

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_unit_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [INSN_W-1:0] insnWord,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic [BYTE_W-1:0] sfbrByte,
  input  logic              carryFlag,
  input  logic              selTimeoutPending,
  output brStrobe_t         strobes
);

  logic [BYTE_W-1:0]  dataMask;
  logic [BYTE_W-1:0]  dataField;
  logic [PHASE_W-1:0] phaseField;
  logic [OPC_W-1:0]   opCode;
  logic               polarity;
  logic               condVal;
  logic               taken;
  logic               unusedBits;

  assign dataMask   = ~insnWord[MASK_LO +: BYTE_W];
  assign dataField  = insnWord[DATA_LO +: BYTE_W];
  assign phaseField = insnWord[CMP_PH_LO +: PHASE_W];
  assign opCode     = insnWord[OPC_LO +: OPC_W];
  assign polarity   = insnWord[POL_BIT];
  assign unusedBits = ^{insnWord[31:30], insnWord[22], insnWord[16]};

  // Chained compare: stop at the first disagreement with polarity
  always_comb begin
    condVal = polarity;
    if ((condVal == polarity) && insnWord[CARRY_EN])
      condVal = carryFlag;
    if ((condVal == polarity) && insnWord[PHASE_EN])
      condVal = (busPhase == phaseField);
    if ((condVal == polarity) && insnWord[DATA_EN])
      condVal = ((sfbrByte & dataMask) == (dataField & dataMask));
    taken = (condVal == polarity);
  end

  always_comb begin
    strobes = '0;
    strobes.relTarget = insnWord[REL_BIT];
    if (selTimeoutPending) begin
      strobes.timeoutStop = 1'b1;
    end else if (taken) begin
      case (opCode)
        OP_JUMP:   strobes.pcFromTarget = 1'b1;
        OP_CALL: begin
          strobes.pcFromTarget = 1'b1;
          strobes.saveTemp     = 1'b1;
        end
        OP_RETURN: strobes.pcFromTemp = 1'b1;
        OP_INTR: begin
          if (insnWord[FLY_BIT]) begin
            strobes.raiseFly = 1'b1;
          end else begin
            strobes.loadStatus = 1'b1;
            strobes.raiseHalt  = 1'b1;
          end
        end
        default:   strobes.raiseIllegal = 1'b1;
      endcase
    end
  end

  // R3
  uncond_jump_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !selTimeoutPending && !insnWord[CARRY_EN] && !insnWord[PHASE_EN]
     && !insnWord[DATA_EN] && (insnWord[29:27] == 3'd0)) |-> strobes.pcFromTarget);

  // R12
  timeout_no_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && selTimeoutPending) |-> (!strobes.saveTemp && !strobes.raiseIllegal
     && !strobes.raiseHalt && !strobes.raiseFly));

endmodule

// File: rtl/branch_dpath.sv
module branch_dpath
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  brStrobe_t         strobes,
  input  logic [ADDR_W-1:0] operandWord,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] tempIn,
  output logic              done,
  output logic [ADDR_W-1:0] pcOut,
  output logic              tempWrite,
  output logic [ADDR_W-1:0] tempOut,
  output logic              statusWrite,
  output logic [ADDR_W-1:0] statusOut,
  output logic              scriptIrq,
  output logic              flyIrq,
  output logic              illegalFault,
  output logic              timeoutHalt
);

  localparam int EXT_W = ADDR_W - OFFSET_W;

  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pcNext;

  assign offsetExt = {{EXT_W{operandWord[OFFSET_W-1]}}, operandWord[OFFSET_W-1:0]};
  assign target    = strobes.relTarget ? (pcIn + offsetExt) : operandWord;

  always_comb begin
    pcNext = pcIn;
    if (strobes.pcFromTarget)    pcNext = target;
    else if (strobes.pcFromTemp) pcNext = tempIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done         <= 1'b0;
      pcOut        <= '0;
      tempWrite    <= 1'b0;
      tempOut      <= '0;
      statusWrite  <= 1'b0;
      statusOut    <= '0;
      scriptIrq    <= 1'b0;
      flyIrq       <= 1'b0;
      illegalFault <= 1'b0;
      timeoutHalt  <= 1'b0;
    end else begin
      done         <= start;
      tempWrite    <= start && strobes.saveTemp;
      statusWrite  <= start && strobes.loadStatus;
      scriptIrq    <= start && strobes.raiseHalt;
      flyIrq       <= start && strobes.raiseFly;
      illegalFault <= start && strobes.raiseIllegal;
      timeoutHalt  <= start && strobes.timeoutStop;
      if (start) begin
        pcOut <= pcNext;
        if (strobes.saveTemp)   tempOut   <= pcIn;
        if (strobes.loadStatus) statusOut <= operandWord;
      end
    end
  end

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  // R2
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(tempWrite || statusWrite || scriptIrq || flyIrq || illegalFault || timeoutHalt));

  // R9
  call_saves_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    tempWrite |-> (tempOut == $past(pcIn)));

  // R10
  event_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({scriptIrq, flyIrq, illegalFault, timeoutHalt}));

  // R12
  timeout_holds_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHalt |-> (pcOut == $past(pcIn)) && !tempWrite && !statusWrite);

  // R10
  status_with_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWrite |-> scriptIrq && (statusOut == $past(operandWord)));

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PHASE_W  = 3,
  parameter int BYTE_W   = 8,
  parameter int OFFSET_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSN_W-1:0]  insnWord,
  input  logic [ADDR_W-1:0]  operandWord,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic [BYTE_W-1:0]  sfbrByte,
  input  logic               carryFlag,
  input  logic [ADDR_W-1:0]  pcIn,
  input  logic [ADDR_W-1:0]  tempIn,
  input  logic               selTimeoutPending,
  output logic               done,
  output logic [ADDR_W-1:0]  pcOut,
  output logic               tempWrite,
  output logic [ADDR_W-1:0]  tempOut,
  output logic               statusWrite,
  output logic [ADDR_W-1:0]  statusOut,
  output logic               scriptIrq,
  output logic               flyIrq,
  output logic               illegalFault,
  output logic               timeoutHalt
);

  brStrobe_t strobes;

  branch_ctrl #(.PHASE_W(PHASE_W), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .insnWord(insnWord),
    .busPhase(busPhase), .sfbrByte(sfbrByte), .carryFlag(carryFlag),
    .selTimeoutPending(selTimeoutPending), .strobes(strobes)
  );

  branch_dpath #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) uDpath (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes),
    .operandWord(operandWord), .pcIn(pcIn), .tempIn(tempIn),
    .done(done), .pcOut(pcOut), .tempWrite(tempWrite), .tempOut(tempOut),
    .statusWrite(statusWrite), .statusOut(statusOut), .scriptIrq(scriptIrq),
    .flyIrq(flyIrq), .illegalFault(illegalFault), .timeoutHalt(timeoutHalt)
  );

endmodule

// File: tb/tb_branch_unit.sv
`timescale 1ns/1ps
module tb_branch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insnWord = '0, operandWord = '0, pcIn = '0, tempIn = '0;
  logic [2:0]  busPhase = '0;
  logic [7:0]  sfbrByte = '0;
  logic        carryFlag = 1'b0, selTimeoutPending = 1'b0;
  logic        done, tempWrite, statusWrite, scriptIrq, flyIrq, illegalFault, timeoutHalt;
  logic [31:0] pcOut, tempOut, statusOut;

  always #2.5 clk = ~clk;

  branch_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .insnWord(insnWord),
    .operandWord(operandWord), .busPhase(busPhase), .sfbrByte(sfbrByte),
    .carryFlag(carryFlag), .pcIn(pcIn), .tempIn(tempIn),
    .selTimeoutPending(selTimeoutPending), .done(done), .pcOut(pcOut),
    .tempWrite(tempWrite), .tempOut(tempOut), .statusWrite(statusWrite),
    .statusOut(statusOut), .scriptIrq(scriptIrq), .flyIrq(flyIrq),
    .illegalFault(illegalFault), .timeoutHalt(timeoutHalt)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        tw;
    logic [31:0] tv;
    logic        sw;
    logic [31:0] sv;
    logic        si;
    logic        fly;
    logic        ill;
    logic        to;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;

  function automatic logic [31:0] mkInsn(input logic [2:0] opc, input logic [2:0] ph,
      input logic rel, input logic cEn, input logic fly, input logic pol,
      input logic dEn, input logic pEn, input logic [7:0] msk, input logic [7:0] dat);
    mkInsn = {2'b10, opc, ph, rel, 1'b0, cEn, fly, pol, dEn, pEn, 1'b0, msk, dat};
  endfunction

  function automatic exp_t mkExp(input logic [31:0] pc, input logic tw, input logic [31:0] tv,
      input logic sw, input logic [31:0] sv, input logic si, input logic fly,
      input logic ill, input logic to);
    mkExp = '{pc: pc, tw: tw, tv: tv, sw: sw, sv: sv, si: si, fly: fly, ill: ill, to: to};
  endfunction

  function automatic exp_t onlyPc(input logic [31:0] pc);
    onlyPc = mkExp(pc, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endfunction

  task automatic send(input logic [31:0] insn, input logic [31:0] op, input logic [2:0] ph,
      input logic [7:0] sb, input logic cy, input logic [31:0] pc, input logic [31:0] tp,
      input logic to, input exp_t e, input string tag);
    @(negedge clk);
    insnWord = insn; operandWord = op; busPhase = ph; sfbrByte = sb;
    carryFlag = cy; pcIn = pc; tempIn = tp; selTimeoutPending = to;
    start = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    selTimeoutPending = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done) begin
        exp_t  e;
        exp_t  a;
        string t;
        a = mkExp(pcOut, tempWrite, tempWrite ? tempOut : 32'h0, statusWrite,
                  statusWrite ? statusOut : 32'h0, scriptIrq, flyIrq, illegalFault, timeoutHalt);
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected done: actual=%h expected=<none>", a);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual pc=%h tw=%b tv=%h sw=%b sv=%h si=%b fly=%b ill=%b to=%b expected pc=%h tw=%b tv=%h sw=%b sv=%h si=%b fly=%b ill=%b to=%b",
              t, a.pc, a.tw, a.tv, a.sw, a.sv, a.si, a.fly, a.ill, a.to,
              e.pc, e.tw, e.tv, e.sw, e.sv, e.si, e.fly, e.ill, e.to);
          end
        end
      end else if (tempWrite || statusWrite || scriptIrq || flyIrq || illegalFault || timeoutHalt) begin
        checks++;
        errors++;
        $display("FAIL R2 strobe without done: actual=1 expected=0");
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] PC = 32'h0000_1000;
  localparam logic [31:0] TP = 32'h0000_2000;
  localparam logic [31:0] OP = 32'h0000_4000;

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if ({done, tempWrite, statusWrite, scriptIrq, flyIrq, illegalFault, timeoutHalt} !== 7'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b expected=0000000",
        {done, tempWrite, statusWrite, scriptIrq, flyIrq, illegalFault, timeoutHalt});
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 unconditional, both polarities
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd5, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R3 uncond pol0");
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00), OP, 3'd5, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R3 uncond pol1");
    // R4 carry compare
    send(mkInsn(3'd0, 3'd0, 0, 1, 0, 1, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b1, PC, TP, 1'b0, onlyPc(OP), "R4 carry true");
    send(mkInsn(3'd0, 3'd0, 0, 1, 0, 1, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R4 R13 carry false");
    send(mkInsn(3'd0, 3'd0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R4 jump if no carry");
    // R5 phase compare
    send(mkInsn(3'd0, 3'd3, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00), OP, 3'd3, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R5 phase match");
    send(mkInsn(3'd0, 3'd3, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00), OP, 3'd2, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R5 phase mismatch");
    send(mkInsn(3'd0, 3'd6, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00), OP, 3'd1, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R5 jump if phase differs");
    // R6 data compare with inverted mask: mask field 0x0F ignores low nibble
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 1, 1, 0, 8'h0F, 8'hA5), OP, 3'd0, 8'hA3, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R6 masked match");
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 1, 1, 0, 8'h0F, 8'hA5), OP, 3'd0, 8'hB5, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R6 masked mismatch");
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 1, 1, 0, 8'hFF, 8'h12), OP, 3'd0, 8'hEE, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R6 all bits masked");
    // R7 chain short-circuit
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 0, 0, 1, 8'h00, 8'h00), OP, 3'd1, 8'h00, 1'b1, PC, TP, 1'b0, onlyPc(PC), "R7 pol0 carry stops chain");
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 0, 0, 1, 8'h00, 8'h00), OP, 3'd4, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R7 pol0 phase decides false");
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 0, 0, 1, 8'h00, 8'h00), OP, 3'd1, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(OP), "R7 pol0 phase decides true");
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 1, 1, 1, 8'h00, 8'h77), OP, 3'd4, 8'h77, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R7 pol1 carry false stops");
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 1, 1, 1, 8'h00, 8'h77), OP, 3'd4, 8'h76, 1'b1, PC, TP, 1'b0, onlyPc(PC), "R7 pol1 data last");
    send(mkInsn(3'd0, 3'd4, 0, 1, 0, 1, 1, 1, 8'h00, 8'h77), OP, 3'd4, 8'h77, 1'b1, PC, TP, 1'b0, onlyPc(OP), "R7 pol1 all true");
    // R8 relative and absolute targets
    send(mkInsn(3'd0, 3'd0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00), 32'h00FF_FFF0, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(32'h0000_0FF0), "R8 negative offset");
    send(mkInsn(3'd0, 3'd0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00), 32'hAB00_0020, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(32'h0000_1020), "R8 upper byte ignored");
    send(mkInsn(3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), 32'hAB00_0020, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(32'hAB00_0020), "R8 absolute full word");
    // R9 call, return
    send(mkInsn(3'd1, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0,
         mkExp(OP, 1'b1, PC, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0), "R9 call absolute");
    send(mkInsn(3'd1, 3'd0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00), 32'h0000_0100, 3'd0, 8'h00, 1'b0, 32'h0000_3000, TP, 1'b0,
         mkExp(32'h0000_3100, 1'b1, 32'h0000_3000, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0), "R9 call relative");
    send(mkInsn(3'd1, 3'd0, 0, 1, 0, 1, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R9 R13 call not taken");
    send(mkInsn(3'd2, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(TP), "R9 return");
    // R10 interrupt forms
    send(mkInsn(3'd3, 3'd0, 0, 0, 1, 0, 0, 0, 8'h00, 8'h00), 32'hDEAD_0001, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0,
         mkExp(PC, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0), "R10 fly");
    send(mkInsn(3'd3, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), 32'hDEAD_0002, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0,
         mkExp(PC, 1'b0, '0, 1'b1, 32'hDEAD_0002, 1'b1, 1'b0, 1'b0, 1'b0), "R10 halting");
    send(mkInsn(3'd3, 3'd2, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00), 32'hDEAD_0003, 3'd5, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R10 R13 interrupt not taken");
    // R11 illegal codes
    for (int c = 4; c < 8; c++)
      send(mkInsn(3'(c), 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0,
           mkExp(PC, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0), "R11 illegal code");
    send(mkInsn(3'd5, 3'd0, 0, 1, 0, 1, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b0, onlyPc(PC), "R11 R13 illegal not taken");
    // R12 selection timeout pending
    send(mkInsn(3'd1, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b1,
         mkExp(PC, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1), "R12 timeout over call");
    send(mkInsn(3'd6, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), OP, 3'd0, 8'h00, 1'b0, PC, TP, 1'b1,
         mkExp(PC, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1), "R12 timeout over illegal");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing done: actual=%0d pending expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule